// File: doc/BRIEF.md
# SD Card SPI Command Framer

This block sends one SD-card command in SPI mode and collects the card's answer. A host presents a 6-bit command index, a 32-bit argument, a response-length select and a speed select, and then pulses `start`. The block builds the 48-bit command frame and works out the CRC7 itself. It shifts the frame out most significant bit first on `mosi`, while it generates `sclk` from the system clock through clock enables. It then clocks out all-ones bytes and watches `miso` for the card's reply. The reply is either a single R1 status byte or a 40-bit reply whose first byte is R1. Chip select is driven outside the block.

The serial clock idles low. `mosi` changes after a falling `sclk` edge, and `miso` is sampled on each rising edge, as in SPI mode 0. Two half-period settings are available: a slow one for card bring-up in the 100 to 400 kHz range (125 system cycles at 50 MHz) and a fast one for normal work (1 system cycle, giving 25 MHz). The choice is captured when the transaction starts.

The controller has four states. `ST_IDLE` moves to `ST_SEND` on `start`. `ST_SEND` moves to `ST_HUNT` after the falling edge that follows the 48th bit. `ST_HUNT` evaluates each received byte. A byte with its top bit clear is the R1 byte: the controller returns to `ST_IDLE` for a short reply, or moves to `ST_TAIL` for a long one. After the last allowed byte with no reply, the controller returns to `ST_IDLE` with a timeout. `ST_TAIL` returns to `ST_IDLE` after 32 more bits.

Top module: `sdspi_cmd_framer`

## Requirements
- R1: The frame is 48 bits sent MSB first, one bit per rising `sclk` edge. Bit 47 is 0, bit 46 is 1, bits 45..40 carry `cmd_index`, bits 39..8 carry `cmd_arg`, bits 7..1 carry the CRC7 and bit 0 is 1. Index and argument are taken at `start`.
- R2: The CRC7 uses the generator x^7+x^3+1 over frame bits 47..8 with a zero initial remainder. Index 0 with argument 0 therefore ends in byte 0x95, and index 8 with argument 0x000001AA ends in byte 0x87.
- R3: While idle, `sclk` is low and `mosi` is high. While the block waits for and receives the reply, `mosi` stays high.
- R4: `mosi` only changes while `sclk` is low. `miso` is sampled on rising `sclk` edges.
- R5: Every `sclk` high phase lasts FAST_HALF system cycles if `speed_fast` was 1 at `start`, and SLOW_HALF cycles otherwise. Changing `speed_fast` during a transaction has no effect on that transaction.
- R6: Reply hunting is byte-aligned to the end of the frame. The first byte whose bit 7 is 0 is taken as R1. A reply found in hunt byte k (counting from 0) ends after 48+8(k+1) rising edges, plus 32 more for a long reply.
- R7: With `resp_long`=0, `resp_valid` pulses for exactly one cycle and `resp_data` equals {32'b0, R1}.
- R8: With `resp_long`=1, `resp_valid` pulses once and `resp_data` holds 40 received bits, with R1 in bits 39..32, in the order they arrived.
- R9: If HUNT_BYTES bytes all have bit 7 set, `timeout` pulses for one cycle and `resp_valid` does not assert. This happens after 48+8*HUNT_BYTES rising edges.
- R10: A `start` pulse while busy is ignored. The frame, reply length and rate of the running transaction stay the same, and no second transaction follows.
- R11: `busy` is high from the cycle after an accepted `start` and falls in the cycle where `resp_valid` or `timeout` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_long | input | 1 | 1: 40-bit reply, 0: R1 only |
| speed_fast | input | 1 | 1: fast half-period, 0: slow half-period |
| miso | input | 1 | Serial data from the card |
| busy | output | 1 | Transaction in progress |
| resp_valid | output | 1 | One-cycle pulse: `resp_data` is valid |
| resp_data | output | 40 | Captured reply, right-aligned for R1 |
| timeout | output | 1 | One-cycle pulse: no reply within the hunt window |
| sclk | output | 1 | Serial clock to the card |
| mosi | output | 1 | Serial data to the card |

## Verification
The bench sweeps all 64 command indices with computed arguments. It checks every frame bit and the CRC against a polynomial-division model and against two well-known checksum bytes. A wrong generator or initial value would corrupt bits 7..1. The reply delay is swept across every hunt byte up to and past the limit, which catches an off-by-one byte count that times out one byte early or late, and a design that is not byte-aligned would return a shifted R1. A mid-transaction start pulse that also flips the speed and length inputs shows whether those inputs are latched: a design that follows the live inputs would re-frame, stretch or shorten `sclk`, or return the wrong reply width. The `sclk` high time is measured on every transaction to catch a swapped or miscounted divider.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_HUNT,
        ST_TAIL
    } sdcf_state_e;

    localparam int FRAME_W  = 48;
    localparam int HEAD_W   = 40;
    localparam int CRC_W    = 7;
    localparam int R1_W     = 8;
    localparam int LONG_W   = 40;
    localparam int TAIL_W   = LONG_W - R1_W;
    localparam logic [CRC_W-1:0] CRC_TAPS = 7'h09;

endpackage

// File: rtl/sdcf_crc7.sv
module sdcf_crc7
    import sdcf_pkg::*;
#(
    parameter int DATA_W = HEAD_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = data[i] ^ acc[CRC_W-1];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
        end
        crc = acc;
    end

endmodule

// File: rtl/sdcf_sclk_gen.sv
module sdcf_sclk_gen #(
    parameter int SLOW_HALF = 125,
    parameter int FAST_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast_sel,
    output logic tick
);

    localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim  = fast_sel ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sdspi_cmd_framer.sv
module sdspi_cmd_framer
    import sdcf_pkg::*;
#(
    parameter int SLOW_HALF  = 125,
    parameter int FAST_HALF  = 1,
    parameter int HUNT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [5:0]        cmd_index,
    input  logic [31:0]       cmd_arg,
    input  logic              resp_long,
    input  logic              speed_fast,
    input  logic              miso,
    output logic              busy,
    output logic              resp_valid,
    output logic [LONG_W-1:0] resp_data,
    output logic              timeout,
    output logic              sclk,
    output logic              mosi
);

    localparam int BIT_CW = $clog2(FRAME_W + 1);
    localparam int HB_CW  = $clog2(HUNT_BYTES + 1);

    sdcf_state_e         state_q, state_d;
    logic [FRAME_W-1:0]  sh_q;
    logic [LONG_W-1:0]   rx_q;
    logic [LONG_W-1:0]   resp_data_q;
    logic [BIT_CW-1:0]   bit_q;
    logic [HB_CW-1:0]    byte_q;
    logic                long_q, spd_q, sclk_q;
    logic                valid_q, tmo_q;

    logic [HEAD_W-1:0]   head;
    logic [CRC_W-1:0]    crc;
    logic                run, tick, rise, fall;
    logic                frame_end, byte_end, tail_end, r1_seen, last_byte;

    assign head = {2'b01, cmd_index, cmd_arg};

    sdcf_crc7 #(.DATA_W(HEAD_W)) u_crc (
        .data (head),
        .crc  (crc)
    );

    assign run = (state_q != ST_IDLE);

    sdcf_sclk_gen #(
        .SLOW_HALF (SLOW_HALF),
        .FAST_HALF (FAST_HALF)
    ) u_sclk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .fast_sel (spd_q),
        .tick     (tick)
    );

    assign rise      = tick && !sclk_q;
    assign fall      = tick && sclk_q;
    assign frame_end = fall && (bit_q == BIT_CW'(FRAME_W));
    assign byte_end  = fall && (bit_q == BIT_CW'(R1_W));
    assign tail_end  = fall && (bit_q == BIT_CW'(TAIL_W));
    assign r1_seen   = !rx_q[R1_W-1];
    assign last_byte = (byte_q == HB_CW'(HUNT_BYTES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (frame_end) state_d = ST_HUNT;
            ST_HUNT: begin
                if (byte_end) begin
                    if (r1_seen) state_d = long_q ? ST_TAIL : ST_IDLE;
                    else if (last_byte) state_d = ST_IDLE;
                end
            end
            ST_TAIL: if (tail_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q        <= '1;
            rx_q        <= '1;
            resp_data_q <= '0;
            bit_q       <= '0;
            byte_q      <= '0;
            long_q      <= 1'b0;
            spd_q       <= 1'b0;
            sclk_q      <= 1'b0;
            valid_q     <= 1'b0;
            tmo_q       <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            tmo_q   <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    sh_q   <= {head, crc, 1'b1};
                    rx_q   <= '1;
                    bit_q  <= '0;
                    byte_q <= '0;
                    long_q <= resp_long;
                    spd_q  <= speed_fast;
                    sclk_q <= 1'b0;
                end
            end else if (rise) begin
                sclk_q <= 1'b1;
                bit_q  <= bit_q + 1'b1;
                if (state_q != ST_SEND) rx_q <= {rx_q[LONG_W-2:0], miso};
            end else if (fall) begin
                sclk_q <= 1'b0;
                unique case (state_q)
                    ST_SEND: begin
                        sh_q <= {sh_q[FRAME_W-2:0], 1'b1};
                        if (frame_end) bit_q <= '0;
                    end
                    ST_HUNT: begin
                        if (byte_end) begin
                            bit_q <= '0;
                            if (r1_seen) begin
                                if (!long_q) begin
                                    valid_q     <= 1'b1;
                                    resp_data_q <= {{TAIL_W{1'b0}}, rx_q[R1_W-1:0]};
                                end
                            end else begin
                                byte_q <= byte_q + 1'b1;
                                if (last_byte) tmo_q <= 1'b1;
                            end
                        end
                    end
                    ST_TAIL: begin
                        if (tail_end) begin
                            valid_q     <= 1'b1;
                            resp_data_q <= rx_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy       = run;
    assign sclk       = sclk_q;
    assign mosi       = (state_q == ST_SEND) ? sh_q[FRAME_W-1] : 1'b1;
    assign resp_valid = valid_q;
    assign timeout    = tmo_q;
    assign resp_data  = resp_data_q;

    // R3
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && mosi));

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R9
    tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!resp_valid && !sclk));

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || timeout) |-> $fell(busy));

endmodule

// File: tb/sdspi_cmd_framer_tb.sv
module sdspi_cmd_framer_tb;

    localparam int SLOW = 4;
    localparam int FAST = 1;
    localparam int HB   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        resp_long = 1'b0;
    logic        speed_fast = 1'b0;
    logic        miso = 1'b1;
    logic        busy, resp_valid, timeout, sclk, mosi;
    logic [39:0] resp_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdspi_cmd_framer #(
        .SLOW_HALF (SLOW),
        .FAST_HALF (FAST),
        .HUNT_BYTES(HB)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd_index  (cmd_index),
        .cmd_arg    (cmd_arg),
        .resp_long  (resp_long),
        .speed_fast (speed_fast),
        .miso       (miso),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .timeout    (timeout),
        .sclk       (sclk),
        .mosi       (mosi)
    );

    // card model
    int          rise_cnt = 0;
    logic [47:0] cap = '0;
    bit          hunt_mosi_low = 0;
    int          card_delay = 0;
    int          card_len = 8;
    logic [39:0] card_resp = '0;

    function automatic logic card_bit(input int idx);
        int j;
        if (idx < 48) return 1'b1;
        j = idx - 48 - card_delay * 8;
        if (j < 0) return 1'b1;
        if (j < card_len) return card_resp[card_len - 1 - j];
        return 1'b1;
    endfunction

    always @(posedge sclk) begin
        if (rise_cnt < 48) cap = {cap[46:0], mosi};
        else if (!mosi) hunt_mosi_low = 1;
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge sclk) miso = card_bit(rise_cnt);

    // sclk high-phase measurement and pulse counters
    int hi_run = 0, hi_min = 1000, hi_max = 0;
    int nvalid = 0, ntmo = 0;
    always @(posedge clk) begin
        if (sclk) hi_run = hi_run + 1;
        else if (hi_run > 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (resp_valid) nvalid = nvalid + 1;
        if (timeout) ntmo = ntmo + 1;
    end

    function automatic logic [6:0] crc_ref(input logic [39:0] d);
        logic [46:0] r;
        r = {d, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (r[i]) r = r ^ (47'h89 << (i - 7));
        return r[6:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic lng, input logic fst, input int dly,
                           input logic [39:0] rsp, input logic poke);
        int v0, t0, lim, exp_rises;
        logic [47:0] ef;
        logic [39:0] rd;
        logic gv, gt;
        card_delay = dly;
        card_len   = lng ? 40 : 8;
        card_resp  = rsp;
        rise_cnt   = 0;
        cap        = '0;
        hunt_mosi_low = 0;
        hi_min = 1000;
        hi_max = 0;
        miso = 1'b1;
        v0 = nvalid;
        t0 = ntmo;
        @(negedge clk);
        cmd_index = idx; cmd_arg = arg; resp_long = lng; speed_fast = fst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", {63'b0, busy}, 64'd1);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1; cmd_index = ~idx; cmd_arg = ~arg; resp_long = ~lng; speed_fast = ~fst;
            @(negedge clk);
            start = 1'b0;
        end
        lim = 0;
        while (!(resp_valid || timeout) && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        chk("R11 completion seen", {63'b0, lim < 20000}, 64'd1);
        rd = resp_data; gv = resp_valid; gt = timeout;
        @(negedge clk);
        chk("R7 pulse width", {62'b0, resp_valid, timeout}, 64'd0);
        chk("R11 busy cleared", {63'b0, busy}, 64'd0);
        ef = {2'b01, idx, arg, crc_ref({2'b01, idx, arg}), 1'b1};
        chk("R1 frame bits", {16'b0, cap}, {16'b0, ef});
        chk("R2 crc field", {57'b0, cap[7:1]}, {57'b0, crc_ref({2'b01, idx, arg})});
        chk("R3 mosi high while hunting", {63'b0, hunt_mosi_low}, 64'd0);
        chk("R5 sclk high phase", {hi_min[31:0], hi_max[31:0]},
            {(fst ? FAST : SLOW), (fst ? FAST : SLOW)});
        if (dly >= HB) begin
            chk("R9 timeout only", {62'b0, gv, gt}, 64'd1);
            chk("R9 counts", {nvalid - v0, ntmo - t0}, {32'd0, 32'd1});
            chk("R9 edge count", rise_cnt, 48 + HB * 8);
        end else begin
            exp_rises = 48 + (dly + 1) * 8 + (lng ? 32 : 0);
            chk("R6 edge count", rise_cnt, exp_rises);
            chk("R7 valid only", {62'b0, gv, gt}, 64'd2);
            if (lng) chk("R8 long reply", {24'b0, rd}, {24'b0, rsp});
            else     chk("R7 short reply", {24'b0, rd}, {56'b0, rsp[7:0]});
        end
        if (poke) begin
            repeat (40) @(negedge clk);
            chk("R10 no second transaction", {busy, 31'b0, nvalid - v0}, 64'd1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset lines", {62'b0, sclk, mosi}, 64'd1);
        chk("R11 reset idle", {61'b0, busy, resp_valid, timeout}, 64'd0);

        // R2 known checksum bytes
        run_cmd(6'd0, 32'h0, 1'b0, 1'b1, 1, 40'h01, 1'b0);
        chk("R2 index0 tail byte", {56'b0, cap[7:0]}, 64'h95);
        run_cmd(6'd8, 32'h1AA, 1'b1, 1'b0, 2, 40'h01_0000_01AA, 1'b0);
        chk("R2 index8 tail byte", {56'b0, cap[7:0]}, 64'h87);

        // R1 R6 R7: sweep of all indices, short reply, rotating delay
        for (int i = 0; i < 64; i++)
            run_cmd(6'(i), 32'(i) * 32'h9E37_79B9, 1'b0, 1'b1, i % HB,
                    {32'b0, 1'b0, 6'(i), i[0]}, 1'b0);

        // R8: long replies at every delay
        for (int d = 0; d < HB; d++)
            run_cmd(6'(58 - d), 32'h4000_0000 ^ 32'(d), 1'b1, 1'b1, d,
                    {1'b0, 7'(d * 13), 32'hC0FF_8000 + 32'(d)}, 1'b0);

        // R7 R1 byte extremes
        run_cmd(6'd55, 32'h0, 1'b0, 1'b1, 0, 40'h00, 1'b0);
        run_cmd(6'd41, 32'hFFFF_FFFF, 1'b0, 1'b1, 7, 40'h7F, 1'b0);

        // R9: timeouts at and beyond the limit, both rates
        run_cmd(6'd17, 32'h1234_5678, 1'b0, 1'b1, HB, 40'h05, 1'b0);
        run_cmd(6'd18, 32'h0, 1'b1, 1'b0, HB + 1, 40'h05, 1'b0);

        // R5: slow rate
        run_cmd(6'd12, 32'hA5A5_5A5A, 1'b0, 1'b0, 3, 40'h04, 1'b0);

        // R10 R5: start and input changes while busy
        run_cmd(6'd25, 32'hDEAD_BEEF, 1'b0, 1'b0, 1, 40'h02, 1'b1);
        run_cmd(6'd9, 32'h0BAD_F00D, 1'b1, 1'b1, 2, 40'h00_8765_4321, 1'b1);

        finish_run();
    end

endmodule